// File: doc/BRIEF.md
# PS/2 Keyboard Key Event Decoder

This block listens to the clock and data lines of a PS/2 keyboard and turns the serial frames it receives into key events. Each frame carries one byte. The block checks the framing and the parity of every frame. It then collapses the extended prefix byte (0xE0) and the key-up prefix byte (0xF0) into flags on the event for the scan code that follows them.

Both lines pass through a two-flop synchroniser. The block accepts a keyboard clock falling edge only after the synchronised clock has stayed low for a programmable number of system clocks, so short glitches are rejected. If a frame stalls partway through, a timeout discards the partial frame. The downstream logic sees one single-cycle strobe per key event, with the scan code and two flags. It also sees a single-cycle error pulse for each corrupted frame.

Top module: `ps2_key_decoder`

## Requirements
- R1: After reset, `evt_valid` and `frame_err` are low, and no prefix is pending.
- R2: A frame is a 0 start bit, eight data bits least significant first, an odd parity bit and a 1 stop bit, each sampled at a filtered falling edge of the keyboard clock. A valid frame whose byte is neither 0xE0 nor 0xF0 yields one `evt_valid` cycle, with `evt_code` equal to that byte.
- R3: A frame whose nine data-plus-parity bits hold an even number of ones raises `frame_err` for exactly one cycle and yields no event.
- R4: A frame whose stop bit is 0 raises `frame_err` for one cycle and yields no event.
- R5: After a valid 0xF0 byte, the next event has `evt_released` = 1. Otherwise `evt_released` = 0.
- R6: After a valid 0xE0 byte, the next event has `evt_extended` = 1. The sequence E0, F0, code yields one event with both flags set. Prefix bytes produce no event of their own.
- R7: A frame error clears any pending prefix, so the next event carries neither flag.
- R8: A make code received several times in a row, as a held key repeats, yields a fresh press event each time.
- R9: A low pulse on the keyboard clock shorter than `FILT_LEN` system clocks is not taken as an edge.
- R10: If no filtered falling edge arrives for `TIMEOUT_CYC` system clocks while a frame is in progress, the partial frame is dropped. The next frame is then decoded from its own start bit.
- R11: `evt_valid` and `frame_err` are never high in the same cycle, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_clk | input | 1 | Keyboard clock line (idle high) |
| kb_dat | input | 1 | Keyboard data line (idle high) |
| evt_valid | output | 1 | One-cycle strobe for a key event |
| evt_code | output | 8 | Scan code of the event |
| evt_extended | output | 1 | Event was preceded by 0xE0 |
| evt_released | output | 1 | Event was preceded by 0xF0 (key up) |
| frame_err | output | 1 | One-cycle pulse on a parity or stop-bit error |

## Verification
On every cycle, the embedded assertions check the following. Event and error strobes are exclusive and last a single cycle. Pending prefixes are cleared on every event and every error. A stalled frame is abandoned once the timeout count is reached. The scenario bench covers what only a sequence of frames can show: least-significant-first assembly of the byte, folding of prefixes into flags, repeated make codes, rejection of a bad parity or stop bit, the loss of a prefix after an error, glitch immunity on the clock line, and recovery after a stalled frame.

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder #(
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk,
  input  logic       kb_dat,
  output logic       evt_valid,
  output logic [7:0] evt_code,
  output logic       evt_extended,
  output logic       evt_released,
  output logic       frame_err
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [1:0]    clk_s, dat_s;
  logic [FW-1:0] flt_cnt;
  logic          clk_lvl;
  logic          fall;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          par_bit;
  logic [TW-1:0] idle_cnt;
  logic          ext_pend, rel_pend;
  logic          good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_s <= 2'b11;
      dat_s <= 2'b11;
    end else begin
      clk_s <= {clk_s[0], kb_clk};
      dat_s <= {dat_s[0], kb_dat};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_cnt <= '0;
      clk_lvl <= 1'b1;
    end else if (clk_s[1]) begin
      flt_cnt <= '0;
      clk_lvl <= 1'b1;
    end else if (flt_cnt != FW'(FILT_LEN)) begin
      flt_cnt <= flt_cnt + 1'b1;
    end else begin
      clk_lvl <= 1'b0;
    end
  end

  assign fall = clk_lvl && !clk_s[1] && (flt_cnt == FW'(FILT_LEN));
  assign good = (^{shreg, par_bit}) && dat_s[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt      <= '0;
      shreg        <= '0;
      par_bit      <= 1'b0;
      idle_cnt     <= '0;
      ext_pend     <= 1'b0;
      rel_pend     <= 1'b0;
      evt_valid    <= 1'b0;
      evt_code     <= '0;
      evt_extended <= 1'b0;
      evt_released <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      frame_err <= 1'b0;
      if (fall) begin
        idle_cnt <= '0;
        if (bit_cnt == 4'd0) begin
          if (!dat_s[1]) bit_cnt <= 4'd1;
        end else if (bit_cnt <= 4'd8) begin
          shreg   <= {dat_s[1], shreg[7:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (bit_cnt == 4'd9) begin
          par_bit <= dat_s[1];
          bit_cnt <= 4'd10;
        end else begin
          bit_cnt <= 4'd0;
          if (!good) begin
            frame_err <= 1'b1;
            ext_pend  <= 1'b0;
            rel_pend  <= 1'b0;
          end else if (shreg == 8'hE0) begin
            ext_pend <= 1'b1;
          end else if (shreg == 8'hF0) begin
            rel_pend <= 1'b1;
          end else begin
            evt_valid    <= 1'b1;
            evt_code     <= shreg;
            evt_extended <= ext_pend;
            evt_released <= rel_pend;
            ext_pend     <= 1'b0;
            rel_pend     <= 1'b0;
          end
        end
      end else if (bit_cnt != 4'd0) begin
        if (idle_cnt == TW'(TIMEOUT_CYC)) begin
          bit_cnt  <= 4'd0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && frame_err));
  p_evt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
  p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  p_err_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (!ext_pend && !rel_pend));
  p_evt_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (!ext_pend && !rel_pend));
  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != 4'd0 && !fall && idle_cnt == TW'(TIMEOUT_CYC)) |=> (bit_cnt == 4'd0));
  p_fall_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: tb/test_ps2_key_decoder.sv
module test_ps2_key_decoder;
  localparam int FILT = 4;
  localparam int TMO  = 300;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kb_clk = 1'b1;
  logic kb_dat = 1'b1;
  logic       evt_valid, evt_extended, evt_released, frame_err;
  logic [7:0] evt_code;

  int tests = 0;
  int fails = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ps2_key_decoder #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) i_ps2_key_decoder (
    .clk(clk), .rst_n(rst_n), .kb_clk(kb_clk), .kb_dat(kb_dat),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_extended(evt_extended),
    .evt_released(evt_released), .frame_err(frame_err));

  task automatic send_bit(input logic b);
    @(negedge clk) kb_dat = b;
    repeat (HALF) @(negedge clk);
    kb_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    kb_clk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic bad_par, input logic bad_stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit((~^b) ^ bad_par);
    send_bit(~bad_stop);
    @(negedge clk) kb_dat = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic expect_evt(input logic [7:0] c, input logic e, input logic r, input string t);
    exp_q.push_back({1'b0, e, r, c});
    tag_q.push_back(t);
  endtask

  task automatic expect_err(input string t);
    exp_q.push_back({1'b1, 10'd0});
    tag_q.push_back(t);
  endtask

  always @(negedge clk) begin
    if (rst_n && (evt_valid || frame_err)) begin
      logic [10:0] got, exp;
      string t;
      got = {frame_err, evt_extended, evt_released, evt_code};
      if (frame_err) got[9:0] = '0;
      tests++;
      if (evt_valid && frame_err) begin
        fails++;
        $display("FAIL R11: event and error together, got %h", got);
      end else if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected output %h, expected nothing", got);
      end else begin
        exp = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, got, exp);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    tests++;
    if (evt_valid !== 1'b0 || frame_err !== 1'b0) begin
      fails++;
      $display("FAIL R1: got valid=%b err=%b expected 0 0", evt_valid, frame_err);
    end
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    expect_evt(8'h1C, 0, 0, "R2"); send_frame(8'h1C, 0, 0);
    expect_evt(8'h01, 0, 0, "R2"); send_frame(8'h01, 0, 0);
    expect_evt(8'h80, 0, 0, "R2"); send_frame(8'h80, 0, 0);
    expect_evt(8'h1C, 0, 1, "R5"); send_frame(8'hF0, 0, 0); send_frame(8'h1C, 0, 0);
    expect_evt(8'h75, 1, 0, "R6"); send_frame(8'hE0, 0, 0); send_frame(8'h75, 0, 0);
    expect_evt(8'h75, 1, 1, "R6");
    send_frame(8'hE0, 0, 0); send_frame(8'hF0, 0, 0); send_frame(8'h75, 0, 0);
    for (int k = 0; k < 3; k++) begin
      expect_evt(8'h23, 0, 0, "R8"); send_frame(8'h23, 0, 0);
    end
    expect_err("R3"); send_frame(8'h2B, 1, 0);
    expect_err("R4"); send_frame(8'h2B, 0, 1);
    expect_evt(8'h2B, 0, 0, "R3"); send_frame(8'h2B, 0, 0);
    expect_err("R7"); expect_evt(8'h4A, 0, 0, "R7");
    send_frame(8'hE0, 0, 0); send_frame(8'h11, 1, 0); send_frame(8'h4A, 0, 0);
    expect_err("R7"); expect_evt(8'h4B, 0, 0, "R7");
    send_frame(8'hF0, 0, 0); send_frame(8'h11, 0, 1); send_frame(8'h4B, 0, 0);

    @(negedge clk) kb_dat = 1'b0;
    kb_clk = 1'b0;
    repeat (FILT - 2) @(negedge clk);
    kb_clk = 1'b1;
    kb_dat = 1'b1;
    repeat (HALF) @(negedge clk);
    expect_evt(8'h5A, 0, 0, "R9"); send_frame(8'h5A, 0, 0);

    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    @(negedge clk) kb_dat = 1'b1;
    repeat (TMO + 100) @(negedge clk);
    expect_evt(8'h66, 0, 0, "R10"); send_frame(8'h66, 0, 0);

    repeat (200) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: got %0d missing outputs expected 0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule